// File: doc/BRIEF.md
# Dual-Channel Converter Output Formatter

This block is the digital back end of a two-channel 8-bit converter. Each clock it receives one raw offset-binary sample per channel. It divides the input clock into a sample strobe and recodes the samples into the selected number format. The results go out either on two separate buses or interleaved onto a single bus. Every output is registered and moves only on strobe edges.

The configuration has two possible sources, and a mode input picks between them. In pin mode, three tri-level configuration pins set the format, the division ratio and the bus arrangement. Each pin arrives already sensed as a 2-bit level code. In serial mode, the same three pins carry a serial port that is handled elsewhere, so their level codes are ignored. The configuration then comes from a 6-bit register value supplied as an input.

Top module: `adc_out_fmt`

## Requirements
- R1: When `pin_mode` is 1, the configuration comes from `fmt_pin`, `div_pin` and `osel_pin`. When it is 0, the configuration comes from `reg_cfg`, with format in bits [1:0], division in bits [3:2] and bus arrangement in bits [5:4].
- R2: Each 2-bit configuration code means low for 00, high for 01 and floating for 10. Code 11 is treated as floating.
- R3: The format setting works as follows. Low gives two's complement, which is the sample with its MSB inverted. High gives offset binary, which is the sample unchanged. Floating gives Gray code, which is the sample XOR the sample shifted right by one.
- R4: The division setting gives a ratio N of 1 for low, 2 for high and 4 for floating, and `smp_stb` is high for one cycle in every N. When the ratio or bus arrangement changes, the count restarts. The first strobe then appears N+1 clocks after the change is applied.
- R5: When the bus arrangement is low, each strobe presents the recoded channel A sample on `out_a` and the recoded channel B sample on `out_b`, with `chan_id` at 0.
- R6: When the bus arrangement is high, strobes alternate between channel A (`chan_id`=0) and channel B (`chan_id`=1) on `out_a`, and `out_b` is held at 0. Channel A comes first after a reset or a configuration change.
- R7: When the bus arrangement is floating, channels A and B alternate in the same way on `out_b`, and `out_a` is held at 0.
- R8: In serial mode, changes on the three configuration pins have no effect on the outputs.
- R9: A synchronous reset clears `out_a`, `out_b`, `chan_id` and `smp_stb` to 0. The data outputs and `chan_id` change only in cycles where `smp_stb` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock |
| rst | input | 1 | Synchronous reset, active high |
| pin_mode | input | 1 | 1 selects pin configuration, 0 selects register configuration |
| fmt_pin | input | 2 | Level code of the format pin |
| div_pin | input | 2 | Level code of the divide pin |
| osel_pin | input | 2 | Level code of the bus-arrangement pin |
| reg_cfg | input | 6 | Register configuration {bus, divide, format} |
| samp_a | input | 8 | Raw offset-binary sample, channel A |
| samp_b | input | 8 | Raw offset-binary sample, channel B |
| out_a | output | 8 | Output bus A |
| out_b | output | 8 | Output bus B |
| chan_id | output | 1 | Channel currently on the interleaved bus (1 = B) |
| smp_stb | output | 1 | High in the cycle new output data appears |

## Verification
The hardest case to reach is the restart after a mid-stream configuration change. The bench has to show two things here: the strobe count begins again from zero, and interleaving resumes with channel A rather than wherever the old phase stood. To get there, the bench applies the change between edges, right after an observed strobe. It then counts clocks to the next strobe and checks its channel tag. It also swaps the pin codes while serial mode is active and confirms that nothing moves.

// File: rtl/adc_out_fmt.sv
module adc_out_fmt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         pin_mode,
  input  logic [1:0]   fmt_pin,
  input  logic [1:0]   div_pin,
  input  logic [1:0]   osel_pin,
  input  logic [5:0]   reg_cfg,
  input  logic [W-1:0] samp_a,
  input  logic [W-1:0] samp_b,
  output logic [W-1:0] out_a,
  output logic [W-1:0] out_b,
  output logic         chan_id,
  output logic         smp_stb
);

  localparam logic [W-1:0] MSB = {1'b1, {(W-1){1'b0}}};
  localparam logic [1:0] LOW = 2'd0, HIGH = 2'd1, FLOAT = 2'd2;

  function automatic logic [1:0] lvl(input logic [1:0] code);
    return code[1] ? FLOAT : code;
  endfunction

  logic [5:0] cfg;
  assign cfg = pin_mode ? {osel_pin, div_pin, fmt_pin} : reg_cfg;

  logic [1:0] fmt_l, div_l, osel_l;
  assign fmt_l  = lvl(cfg[1:0]);
  assign div_l  = lvl(cfg[3:2]);
  assign osel_l = lvl(cfg[5:4]);

  function automatic logic [W-1:0] recode(input logic [W-1:0] s, input logic [1:0] f);
    case (f)
      LOW:     return s ^ MSB;
      HIGH:    return s;
      default: return s ^ (s >> 1);
    endcase
  endfunction

  logic [1:0] cnt, last;
  logic [3:0] key, prev_key;
  logic       chg, en, phase;
  logic [W-1:0] hold_b;

  assign last = (div_l == LOW) ? 2'd0 : (div_l == HIGH) ? 2'd1 : 2'd3;
  assign key  = {div_l, osel_l};
  assign chg  = key != prev_key;
  assign en   = !chg && (cnt == last);

  always_ff @(posedge clk) begin
    prev_key <= key;
    if (rst || chg || en) cnt <= '0;
    else                  cnt <= cnt + 2'd1;
    if (rst || chg)                 phase <= 1'b0;
    else if (en && osel_l != LOW)   phase <= ~phase;
    if (en && !phase) hold_b <= samp_b;
  end

  logic [W-1:0] fa, fb, fh;
  assign fa = recode(samp_a, fmt_l);
  assign fb = recode(samp_b, fmt_l);
  assign fh = recode(hold_b, fmt_l);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_a   <= '0;
      out_b   <= '0;
      chan_id <= 1'b0;
      smp_stb <= 1'b0;
    end else begin
      smp_stb <= en;
      if (en) begin
        case (osel_l)
          LOW: begin
            out_a   <= fa;
            out_b   <= fb;
            chan_id <= 1'b0;
          end
          HIGH: begin
            out_a   <= phase ? fh : fa;
            out_b   <= '0;
            chan_id <= phase;
          end
          default: begin
            out_a   <= '0;
            out_b   <= phase ? fh : fa;
            chan_id <= phase;
          end
        endcase
      end
    end
  end

endmodule

module adc_out_fmt_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         smp_stb,
  input logic         chan_id,
  input logic [W-1:0] out_a,
  input logic [W-1:0] out_b,
  input logic [W-1:0] samp_a,
  input logic [1:0]   fmt_l,
  input logic [1:0]   div_l,
  input logic [1:0]   osel_l
);

  p_hold_between_strobes_r9: assert property (@(posedge clk) disable iff (rst)
    (out_a != $past(out_a) || out_b != $past(out_b) || chan_id != $past(chan_id)) |-> smp_stb);

  p_bus_b_idle_r6: assert property (@(posedge clk) disable iff (rst)
    (smp_stb && $past(osel_l) == 2'd1) |-> out_b == '0);

  p_bus_a_idle_r7: assert property (@(posedge clk) disable iff (rst)
    (smp_stb && $past(osel_l) == 2'd2) |-> out_a == '0);

  p_sep_tag_r5: assert property (@(posedge clk) disable iff (rst)
    (smp_stb && $past(osel_l) == 2'd0) |-> !chan_id);

  p_offset_pass_r3: assert property (@(posedge clk) disable iff (rst)
    (smp_stb && $past(fmt_l) == 2'd1 && $past(osel_l) == 2'd0) |-> out_a == $past(samp_a));

  p_div1_every_r4: assert property (@(posedge clk) disable iff (rst)
    (smp_stb && $past(div_l) == 2'd0 && div_l == 2'd0 && $past(osel_l) == osel_l) |=> smp_stb);

endmodule

bind adc_out_fmt adc_out_fmt_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .smp_stb(smp_stb), .chan_id(chan_id),
  .out_a(out_a), .out_b(out_b), .samp_a(samp_a),
  .fmt_l(fmt_l), .div_l(div_l), .osel_l(osel_l)
);

// File: tb/adc_out_fmt_test.sv
module adc_out_fmt_test;
  localparam int CLK_NS = 10;

  logic clk = 0, rst = 1, pin_mode = 1;
  logic [1:0] fmt_pin = 2'b01, div_pin = 2'b00, osel_pin = 2'b00;
  logic [5:0] reg_cfg = 6'd0;
  logic [7:0] samp_a = 8'hB6, samp_b = 8'h35;
  logic [7:0] out_a, out_b;
  logic chan_id, smp_stb;
  int n_chk = 0, n_fail = 0;

  adc_out_fmt #(.W(8)) uut (
    .clk(clk), .rst(rst), .pin_mode(pin_mode), .fmt_pin(fmt_pin),
    .div_pin(div_pin), .osel_pin(osel_pin), .reg_cfg(reg_cfg),
    .samp_a(samp_a), .samp_b(samp_b), .out_a(out_a), .out_b(out_b),
    .chan_id(chan_id), .smp_stb(smp_stb)
  );

  always #(CLK_NS/2) clk = ~clk;

  function automatic logic [7:0] twos(input logic [7:0] s); return {~s[7], s[6:0]}; endfunction
  function automatic logic [7:0] gray(input logic [7:0] s); return s ^ {1'b0, s[7:1]}; endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_stb(output int cycles);
    cycles = 0;
    do begin
      @(negedge clk);
      cycles++;
    end while (!smp_stb && cycles < 20);
  endtask

  task automatic t_reset;
    rst = 1;
    repeat (3) @(negedge clk);
    chk("R9 reset out_a", out_a, 0);
    chk("R9 reset out_b", out_b, 0);
    chk("R9 reset chan_id/stb", {chan_id, smp_stb}, 0);
    rst = 0;
  endtask

  task automatic t_formats;
    int c;
    pin_mode = 1; div_pin = 2'b00; osel_pin = 2'b00;
    fmt_pin = 2'b01; wait_stb(c); wait_stb(c);
    chk("R3 offset a", out_a, samp_a);
    chk("R5 separate b", out_b, samp_b);
    chk("R5 chan_id", chan_id, 0);
    fmt_pin = 2'b00; wait_stb(c); wait_stb(c);
    chk("R3 twos a", out_a, twos(samp_a));
    chk("R3 twos b", out_b, twos(samp_b));
    fmt_pin = 2'b10; wait_stb(c); wait_stb(c);
    chk("R3 gray a", out_a, gray(samp_a));
    fmt_pin = 2'b11; samp_a = 8'h0F; wait_stb(c); wait_stb(c);
    chk("R2 code 11 floats to gray", out_a, gray(8'h0F));
    samp_a = 8'hB6;
  endtask

  task automatic t_divide(input logic [1:0] code, input int n);
    int c;
    fmt_pin = 2'b01; osel_pin = 2'b00;
    wait_stb(c);
    div_pin = code;
    wait_stb(c);
    chk($sformatf("R4 restart delay N=%0d", n), c, n + 1);
    wait_stb(c);
    chk($sformatf("R4 period N=%0d", n), c, n);
    wait_stb(c);
    chk($sformatf("R4 period again N=%0d", n), c, n);
  endtask

  task automatic t_interleave(input logic [1:0] code, input bit on_b);
    int c;
    string rq = on_b ? "R7" : "R6";
    fmt_pin = 2'b00; div_pin = 2'b01;
    wait_stb(c);
    osel_pin = code;
    wait_stb(c);
    chk({rq, " first slot is A"}, chan_id, 0);
    chk({rq, " A data"}, on_b ? out_b : out_a, twos(samp_a));
    chk({rq, " idle bus zero"}, on_b ? out_a : out_b, 0);
    wait_stb(c);
    chk({rq, " second slot is B"}, chan_id, 1);
    chk({rq, " B data"}, on_b ? out_b : out_a, twos(samp_b));
    chk({rq, " idle bus zero in B slot"}, on_b ? out_a : out_b, 0);
    wait_stb(c);
    chk({rq, " back to A"}, chan_id, 0);
    osel_pin = 2'b00; wait_stb(c); wait_stb(c);
  endtask

  task automatic t_serial;
    int c;
    pin_mode = 1; fmt_pin = 2'b01; div_pin = 2'b00; osel_pin = 2'b00;
    wait_stb(c); wait_stb(c);
    reg_cfg = {2'b00, 2'b00, 2'b10};
    pin_mode = 0;
    wait_stb(c); wait_stb(c);
    chk("R1 register source gray a", out_a, gray(samp_a));
    chk("R1 register source separate b", out_b, gray(samp_b));
    fmt_pin = 2'b00; osel_pin = 2'b01; div_pin = 2'b10;
    wait_stb(c);
    chk("R8 pins ignored: period", c, 1);
    wait_stb(c);
    chk("R8 pins ignored: a", out_a, gray(samp_a));
    chk("R8 pins ignored: b", out_b, gray(samp_b));
    chk("R8 pins ignored: chan_id", chan_id, 0);
    reg_cfg = {2'b00, 2'b00, 2'b00};
    wait_stb(c); wait_stb(c);
    chk("R1 register format twos", out_a, twos(samp_a));
    pin_mode = 1;
    wait_stb(c); wait_stb(c);
    chk("R1 pin source again (interleave A)", out_b, 0);
  endtask

  initial begin
    #(CLK_NS * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    t_reset;
    t_formats;
    t_divide(2'b01, 2);
    t_divide(2'b10, 4);
    t_divide(2'b00, 1);
    t_interleave(2'b01, 0);
    t_interleave(2'b10, 1);
    t_serial;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule